// File: doc/BRIEF.md
# DRAM Access Cycle Sequencer

This block produces the bus states a small controller's external bus interface needs to read or write one word in DRAM space. A request that targets one of the DRAM-capable areas is taken only while the sequencer is idle. The cycle then runs a fixed series of states: one precharge state, one row-address state and two column-address states. The block drives the multiplexed row and column address, a row strobe on the chip-select line of the requested area, separate column strobes for the upper and lower byte lanes, and a write-enable.

Each request carries a per-area wait-enable bit. This bit only decides whether an external wait input is obeyed. It never changes the length of the base cycle. When waits are allowed and the wait input is high at the end of the first column state, wait states are inserted until the input drops. Read data is captured at the end of the last column state. A one-cycle completion pulse follows in the next cycle.

Top module: `dram_cycle_seq`

## Requirements
- R1: After synchronous reset, every row strobe, both column strobes and the write-enable are high (inactive), the output enable and done are low, and the address output is zero.
- R2: An access without wait states produces done exactly 4 clock edges after the edge that accepts the request: a precharge, a row and two column states.
- R3: The states run in a fixed order. In the precharge state all row strobes are high. In the row state the selected row strobe is low and the address output carries the row, addr_in[2*COL_W-1:COL_W]. In both column states the row strobe stays low and the address output carries the column, addr_in[COL_W-1:0].
- R4: When the request's wait-enable bit is 0, the external wait input has no effect and the access still takes 4 states.
- R5: When the wait-enable bit is 1 and ext_wait is high at the end of the first column state, one wait state is inserted for each consecutive edge at which ext_wait is sampled high. During wait states the row strobe stays low, the column address is held and both column strobes stay high.
- R6: The row strobe appears only on ras_n[area_in-2], for area_in from 2 to 5. All other row strobe lines stay high.
- R7: A read asserts both column strobes low only in the second column state. rdata_out takes the value of dq_in at the end of that state and is valid when done is high.
- R8: A write holds we_n low and dq_oe high, with dq_out equal to wdata_in, from the first column state through the second column state. In the second column state the column strobes follow the byte enables: be_in[1] selects ucas_n and be_in[0] selects lcas_n.
- R9: done is high for exactly one cycle per access. A request that arrives while a cycle is running is dropped. A request whose area is outside 2 to 5 is dropped, with no strobe and no done.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| area_in | input | 3 | Target area number |
| addr_in | input | 18 | Word address (row in upper half, column in lower half) |
| write_in | input | 1 | 1 = write, 0 = read |
| be_in | input | 2 | Byte enables, bit 1 upper, bit 0 lower |
| wdata_in | input | 16 | Write data |
| wait_en_in | input | 1 | Per-area wait insertion enable |
| ext_wait | input | 1 | External wait request, active high |
| dq_in | input | 16 | Read data from memory |
| addr_out | output | 9 | Multiplexed row/column address |
| ras_n | output | 4 | Row strobes on area chip selects 2..5 |
| ucas_n | output | 1 | Upper-byte column strobe |
| lcas_n | output | 1 | Lower-byte column strobe |
| we_n | output | 1 | Write enable |
| dq_out | output | 16 | Write data to memory |
| dq_oe | output | 1 | Data output enable |
| rdata_out | output | 16 | Captured read data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench first runs directed accesses that pair the wait-enable bit with held wait lengths of 0, 1 and 3 cycles. These show whether the wait input is gated by the enable bit and whether the wait count tracks the held cycles exactly. Reads and writes with each byte-enable pattern are then checked state by state, which separates the read column-strobe timing from the write timing and lane selection. Random accesses over all four DRAM areas catch row strobes sent to the wrong line and swapped row and column fields. Requests sent mid-cycle and requests to non-DRAM areas test that nothing starts when it should not.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
    localparam int COL_W      = 9;
    localparam int ADDR_W     = 2 * COL_W;
    localparam int DATA_W     = 16;
    localparam int AREA_W     = 3;
    localparam int FIRST_AREA = 2;
    localparam int NUM_AREAS  = 4;
    localparam int SEL_W      = $clog2(NUM_AREAS);

    typedef enum logic [2:0] {
        ST_IDLE, ST_PRE, ST_ROW, ST_COL1, ST_WAIT, ST_COL2
    } dram_state_e;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [1:0]        be;
        logic [DATA_W-1:0] wdata;
        logic              wen;
    } dram_req_t;

    function automatic logic area_is_dram(input logic [AREA_W-1:0] a);
        return (int'(a) >= FIRST_AREA) && (int'(a) < FIRST_AREA + NUM_AREAS);
    endfunction

    function automatic logic [SEL_W-1:0] area_to_sel(input logic [AREA_W-1:0] a);
        return SEL_W'(int'(a) - FIRST_AREA);
    endfunction
endpackage

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
    import dram_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        wen,
    input  logic        ext_wait,
    output dram_state_e state
);
    dram_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_PRE;
            ST_PRE:  nxt = ST_ROW;
            ST_ROW:  nxt = ST_COL1;
            ST_COL1: nxt = (wen && ext_wait) ? ST_WAIT : ST_COL2;
            ST_WAIT: nxt = ext_wait ? ST_WAIT : ST_COL2;
            ST_COL2: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
    import dram_seq_pkg::*;
(
    input  dram_state_e       state,
    input  logic [ADDR_W-1:0] addr,
    output logic [COL_W-1:0]  addr_out
);
    always_comb begin
        unique case (state)
            ST_ROW:                   addr_out = addr[ADDR_W-1:COL_W];
            ST_COL1, ST_WAIT, ST_COL2: addr_out = addr[COL_W-1:0];
            default:                  addr_out = '0;
        endcase
    end
endmodule

// File: rtl/dram_strobe_gen.sv
module dram_strobe_gen
    import dram_seq_pkg::*;
(
    input  dram_state_e          state,
    input  dram_req_t            req,
    output logic [NUM_AREAS-1:0] ras_n,
    output logic                 ucas_n,
    output logic                 lcas_n,
    output logic                 we_n,
    output logic                 dq_oe
);
    logic row_open, col_phase, last_col;

    assign row_open  = (state == ST_ROW) || (state == ST_COL1) ||
                       (state == ST_WAIT) || (state == ST_COL2);
    assign col_phase = (state == ST_COL1) || (state == ST_WAIT) || (state == ST_COL2);
    assign last_col  = (state == ST_COL2);

    for (genvar g = 0; g < NUM_AREAS; g++) begin : g_ras
        assign ras_n[g] = !(row_open && (req.sel == SEL_W'(g)));
    end

    assign ucas_n = !(last_col && (!req.wr || req.be[1]));
    assign lcas_n = !(last_col && (!req.wr || req.be[0]));
    assign we_n   = !(col_phase && req.wr);
    assign dq_oe  = col_phase && req.wr;
endmodule

// File: rtl/dram_cycle_seq.sv
module dram_cycle_seq
    import dram_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [AREA_W-1:0]    area_in,
    input  logic [ADDR_W-1:0]    addr_in,
    input  logic                 write_in,
    input  logic [1:0]           be_in,
    input  logic [DATA_W-1:0]    wdata_in,
    input  logic                 wait_en_in,
    input  logic                 ext_wait,
    input  logic [DATA_W-1:0]    dq_in,
    output logic [COL_W-1:0]     addr_out,
    output logic [NUM_AREAS-1:0] ras_n,
    output logic                 ucas_n,
    output logic                 lcas_n,
    output logic                 we_n,
    output logic [DATA_W-1:0]    dq_out,
    output logic                 dq_oe,
    output logic [DATA_W-1:0]    rdata_out,
    output logic                 done
);
    dram_state_e state_q;
    dram_req_t   req_q;
    logic        start;

    assign start = req_valid && (state_q == ST_IDLE) && area_is_dram(area_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q     <= '0;
            rdata_out <= '0;
            done      <= 1'b0;
        end else begin
            if (start) begin
                req_q.sel   <= area_to_sel(area_in);
                req_q.addr  <= addr_in;
                req_q.wr    <= write_in;
                req_q.be    <= be_in;
                req_q.wdata <= wdata_in;
                req_q.wen   <= wait_en_in;
            end
            if (state_q == ST_COL2 && !req_q.wr) rdata_out <= dq_in;
            done <= (state_q == ST_COL2);
        end
    end

    dram_seq_fsm u_fsm (
        .clk(clk), .rst(rst), .start(start), .wen(req_q.wen),
        .ext_wait(ext_wait), .state(state_q)
    );

    dram_addr_mux u_mux (.state(state_q), .addr(req_q.addr), .addr_out(addr_out));

    dram_strobe_gen u_stb (
        .state(state_q), .req(req_q), .ras_n(ras_n), .ucas_n(ucas_n),
        .lcas_n(lcas_n), .we_n(we_n), .dq_oe(dq_oe)
    );

    assign dq_out = req_q.wdata;
endmodule

// File: rtl/dram_cycle_seq_chk.sv
module dram_cycle_seq_chk
    import dram_seq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input dram_state_e          state,
    input logic                 wen,
    input logic [NUM_AREAS-1:0] ras_n,
    input logic                 ucas_n,
    input logic                 lcas_n,
    input logic                 we_n,
    input logic                 done
);
    // R6
    ras_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~ras_n));
    // R7
    cas_needs_ras_chk: assert property (@(posedge clk) disable iff (rst)
        (!ucas_n || !lcas_n) |-> (ras_n != '1));
    // R8
    we_needs_ras_chk: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (ras_n != '1));
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R3
    pre_to_row_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PRE) |=> (state == ST_ROW));
    // R3
    row_to_col_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ROW) |=> (state == ST_COL1));
    // R4
    no_wait_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COL1 && !wen) |=> (state == ST_COL2));
    // R3
    pre_ras_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PRE) |-> (ras_n == '1));
endmodule

bind dram_cycle_seq dram_cycle_seq_chk u_chk (
    .clk(clk), .rst(rst), .state(state_q), .wen(req_q.wen), .ras_n(ras_n),
    .ucas_n(ucas_n), .lcas_n(lcas_n), .we_n(we_n), .done(done)
);

// File: tb/dram_cycle_seq_bench.sv
module dram_cycle_seq_bench;
    import dram_seq_pkg::*;

    logic clk = 0, rst = 1;
    logic req_valid = 0, write_in = 0, wait_en_in = 0, ext_wait = 0;
    logic [AREA_W-1:0] area_in = '0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [1:0] be_in = '0;
    logic [DATA_W-1:0] wdata_in = '0, dq_in = '0;
    logic [COL_W-1:0] addr_out;
    logic [NUM_AREAS-1:0] ras_n;
    logic ucas_n, lcas_n, we_n, dq_oe, done;
    logic [DATA_W-1:0] dq_out, rdata_out;
    int tests = 0, fails = 0;

    always #2 clk = ~clk;

    dram_cycle_seq u_dram_cycle_seq (.*);

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NUM_AREAS-1:0] exp_ras(input int area);
        logic [NUM_AREAS-1:0] r = '1;
        r[area - FIRST_AREA] = 1'b0;
        return r;
    endfunction
    function automatic logic [COL_W-1:0] row_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:COL_W];
    endfunction
    function automatic logic [COL_W-1:0] col_of(input logic [ADDR_W-1:0] a);
        return a[COL_W-1:0];
    endfunction

    task automatic access(input int area, input logic [ADDR_W-1:0] a, input bit wr,
                          input logic [1:0] be, input logic [DATA_W-1:0] wd,
                          input bit wen, input int k, input bit spur);
        int nw = wen ? k : 0;
        int rem = k;
        logic [DATA_W-1:0] rd = DATA_W'($urandom);
        logic [NUM_AREAS-1:0] er = exp_ras(area);
        @(negedge clk);
        req_valid = 1; area_in = AREA_W'(area); addr_in = a; write_in = wr;
        be_in = be; wdata_in = wd; wait_en_in = wen;
        @(negedge clk);
        req_valid = 0; ext_wait = (k > 0);
        chk(ras_n == '1, "R3 precharge ras", ras_n, '1);
        chk(done == 0, "R2 no early done", done, 0);
        @(negedge clk);
        chk(ras_n == er, "R6 row ras line", ras_n, er);
        chk(addr_out == row_of(a), "R3 row addr", addr_out, row_of(a));
        if (spur) begin req_valid = 1; area_in = 3'd2; end
        @(negedge clk);
        req_valid = 0;
        chk(addr_out == col_of(a), "R3 col1 addr", addr_out, col_of(a));
        chk(ras_n == er, "R3 col1 ras", ras_n, er);
        chk({ucas_n, lcas_n} == 2'b11, "R7 no cas in col1", {ucas_n, lcas_n}, 3);
        chk(we_n == !wr && dq_oe == wr, "R8 we col1", {we_n, dq_oe}, {!wr, wr});
        for (int i = 0; i < nw; i++) begin
            @(negedge clk);
            rem--;
            if (rem == 0) ext_wait = 0;
            chk(ras_n == er && addr_out == col_of(a), "R5 wait holds row/col",
                {ras_n, addr_out}, {er, col_of(a)});
            chk({ucas_n, lcas_n} == 2'b11, "R5 no cas in wait", {ucas_n, lcas_n}, 3);
        end
        @(negedge clk);
        dq_in = rd;
        chk(ras_n == er, "R3 col2 ras", ras_n, er);
        chk(done == 0, "R2/R4/R5 length", done, 0);
        if (wr) begin
            chk({ucas_n, lcas_n} == ~be, "R8 write cas lanes", {ucas_n, lcas_n}, ~be);
            chk(!we_n && dq_oe && dq_out == wd, "R8 write data", dq_out, wd);
        end else begin
            chk({ucas_n, lcas_n} == 2'b00, "R7 read cas", {ucas_n, lcas_n}, 0);
        end
        @(negedge clk);
        ext_wait = 0;
        chk(done == 1, "R2 done after cycle", done, 1);
        chk(ras_n == '1 && we_n && ucas_n && lcas_n, "R3 strobes released", ras_n, '1);
        if (!wr) chk(rdata_out == rd, "R7 read data", rdata_out, rd);
        @(negedge clk);
        chk(done == 0, "R9 done one cycle", done, 0);
        chk(ras_n == '1, "R9 no spurious start", ras_n, '1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ras_n == '1 && ucas_n && lcas_n && we_n, "R1 reset strobes", ras_n, '1);
        chk(!dq_oe && !done && addr_out == 0, "R1 reset outputs", {dq_oe, done, addr_out}, 0);
        rst = 0;
        // directed: R4 wait ignored, R5 waits counted
        access(2, 18'h2A5F3, 0, 2'b11, 16'h0, 0, 0, 0);
        access(3, 18'h1F00C, 0, 2'b11, 16'h0, 0, 3, 0);   // R4
        access(4, 18'h00123, 1, 2'b10, 16'hBEEF, 1, 1, 0); // R5
        access(5, 18'h3FFFF, 0, 2'b11, 16'h0, 1, 3, 0);   // R5
        access(2, 18'h15555, 1, 2'b01, 16'h1234, 1, 0, 1); // R9 busy request
        access(5, 18'h0ABCD, 1, 2'b11, 16'hA5A5, 0, 2, 0); // R8
        // R9 non-DRAM areas dropped
        for (int a = 0; a < 8; a += 6) begin
            @(negedge clk);
            req_valid = 1; area_in = AREA_W'(a);
            @(negedge clk);
            req_valid = 0;
            for (int c = 0; c < 5; c++) begin
                chk(ras_n == '1 && !done, "R9 bad area ignored", {ras_n, done}, {4'hF, 1'b0});
                @(negedge clk);
            end
        end
        // random mix
        for (int n = 0; n < 40; n++) begin
            access(FIRST_AREA + int'($urandom_range(NUM_AREAS - 1)), ADDR_W'($urandom),
                   bit'($urandom_range(1)), 2'($urandom_range(1, 3)), DATA_W'($urandom),
                   bit'($urandom_range(1)), int'($urandom_range(3)), 0);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule